// File: doc/BRIEF.md
# MII Receive Frame Deserializer

This block takes the nibble-wide receive side of a media-independent interface (a data-enable line, four data lines and an error line, all sampled on the rising edge of the receive clock) and turns each frame into a stream of bytes. The bytes come out on a simple streaming port with a one-cycle valid strobe, start-of-packet and end-of-packet marks, and one error bit per frame.

Each frame begins when the enable line rises. The block then hunts through the leading nibbles for the start-of-frame delimiter and throws away everything up to and including it. From that point it pairs nibbles into bytes, low nibble first. The last byte of every frame is held back for one byte time, so that the end-of-packet mark can ride on it once the enable line falls. Any error pulse that the PHY raises while a frame is in progress is remembered until that frame's end-of-packet beat. A frame that stops on half a byte loses the stray nibble and is flagged as errored.

Top module: `mii_rx_deser`

## Requirements
- R1: All inputs are captured on the rising clock edge. After reset, out_valid, out_sop, out_eop and out_err are 0, and none of them is ever 1 unless a frame with a delimiter has been received.
- R2: A frame starts when mii_rx_en rises. Nibbles are discarded until the two consecutive nibbles 0x5 then 0xD (the delimiter byte 0xD5, taken low nibble first) have been seen, for any number of preamble nibbles, odd or even. A frame with no delimiter produces no output.
- R3: After the delimiter, nibbles are paired into bytes. The first nibble of each pair becomes out_data[3:0] and the second becomes out_data[7:4].
- R4: Each complete byte is delivered exactly once and in order. The first byte of a frame carries out_sop=1 and the last carries out_eop=1, and a one-byte frame carries both on the same beat. out_sop and out_eop are only ever 1 while out_valid is 1.
- R5: If mii_rx_er is 1 in any cycle in which mii_rx_en is 1, whether in the preamble, in the data or on the final nibble, the frame's end-of-packet beat has out_err=1. out_err is 1 only on an end-of-packet beat.
- R6: The error flag clears when the next frame starts, so a clean frame that follows an errored frame ends with out_err=0.
- R7: If an odd number of nibbles follows the delimiter, the trailing nibble is dropped. The complete bytes are still delivered, and the end-of-packet beat has out_err=1.
- R8: A frame that contains no complete byte after the delimiter produces no output beats.
- R9: Two frames separated by a single low cycle of mii_rx_en are delivered as two separate packets with correct marks, and the first frame's error state does not carry into the second.
- R10: mii_rx_d and mii_rx_er are ignored while mii_rx_en is 0: noise on them between frames produces no beats and sets no error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mii_rx_en | input | 1 | Data enable from the PHY, high for the whole frame |
| mii_rx_d | input | 4 | Receive data nibble |
| mii_rx_er | input | 1 | Receive error indication from the PHY |
| out_valid | output | 1 | One-cycle strobe marking a byte beat |
| out_data | output | 8 | Assembled byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_err | output | 1 | Frame error, valid on the end-of-packet beat |

## Verification
Two events can land on the same cycle here. A PHY error can arrive on the very last nibble of a frame, just as the enable drop closes the packet. An odd-nibble truncation can also combine with a late error. The bench drives frames whose error pulse sits on the final nibble, with and without a stray half byte, and frames spaced by a single idle cycle. It then checks that the end-of-packet beat carries the flag and the right byte, and that the next frame starts clean. The expected beats are rebuilt from the driven payload in each case.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } fr_state_t;
endpackage

// File: rtl/mii_rx_sampler.sv
module mii_rx_sampler #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [NIB_W-1:0] rx_d,
  input  logic             rx_er,
  output logic             s_en,
  output logic [NIB_W-1:0] s_d,
  output logic             s_er,
  output logic             frame_start,
  output logic             frame_stop
);
  logic en_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_en <= 1'b0;
      s_d  <= '0;
      s_er <= 1'b0;
      en_d <= 1'b0;
    end else begin
      s_en <= rx_en;
      s_d  <= rx_d;
      s_er <= rx_er;
      en_d <= s_en;
    end
  end

  assign frame_start = s_en & ~en_d;
  assign frame_stop  = ~s_en & en_d;

  // R2: a frame start is a single-cycle event
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
#(
  parameter int               NIB_W  = 4,
  parameter int               BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SFD   = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_en,
  input  logic [NIB_W-1:0]  s_d,
  input  logic              s_er,
  input  logic              frame_start,
  input  logic              frame_stop,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic              byte_first,
  output logic              frame_end,
  output logic              end_err
);
  localparam int NPB = BYTE_W / NIB_W;
  localparam int CW  = (NPB > 1) ? $clog2(NPB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NPB - 1);

  // new nibble enters at the top, so the first one ends up in the low bits
  function automatic logic [BYTE_W-1:0] shift_nib(input logic [BYTE_W-1:0] acc,
                                                  input logic [NIB_W-1:0]  nib);
    return {nib, acc[BYTE_W-1:NIB_W]};
  endfunction

  fr_state_t         state;
  logic [BYTE_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic              first_pend;
  logic              err_sticky;

  logic [BYTE_W-1:0] win;
  logic              hunting;
  logic              sfd_found;
  logic              in_data;

  assign win       = shift_nib(frame_start ? '0 : shreg, s_d);
  assign hunting   = s_en & (frame_start | (state == ST_HUNT));
  assign sfd_found = hunting & (win == SFD);
  assign in_data   = s_en & ~frame_start & (state == ST_DATA);

  assign byte_stb   = in_data & (cnt == LAST);
  assign byte_val   = win;
  assign byte_first = byte_stb & first_pend;
  assign frame_end  = frame_stop & (state == ST_DATA);
  assign end_err    = err_sticky | (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      first_pend <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_sticky <= (frame_start ? 1'b0 : err_sticky) | (s_en & s_er);
      if (!s_en) begin
        state      <= ST_IDLE;
        cnt        <= '0;
        first_pend <= 1'b0;
      end else if (hunting) begin
        if (sfd_found) begin
          state      <= ST_DATA;
          shreg      <= '0;
          cnt        <= '0;
          first_pend <= 1'b1;
        end else begin
          state <= ST_HUNT;
          shreg <= win;
        end
      end else if (in_data) begin
        shreg <= win;
        if (byte_stb) begin
          cnt        <= '0;
          first_pend <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R10: with enable low the framer always returns to idle
  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> (state == ST_IDLE));
  // R5: an error seen inside a frame is remembered
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && s_er) |=> err_sticky);
  // R6: the flag starts each frame clear unless set in its first cycle
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !s_er) |=> !err_sticky);
endmodule

// File: rtl/mii_rx_outstage.sv
module mii_rx_outstage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              byte_first,
  input  logic              frame_end,
  input  logic              end_err,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err
);
  logic              hold_v;
  logic [BYTE_W-1:0] hold_b;
  logic              hold_sop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_b    <= '0;
      hold_sop  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= 1'b0;
      if (byte_stb) begin
        if (hold_v) begin
          out_valid <= 1'b1;
          out_data  <= hold_b;
          out_sop   <= hold_sop;
        end
        hold_v   <= 1'b1;
        hold_b   <= byte_val;
        hold_sop <= byte_first;
      end else if (frame_end) begin
        if (hold_v) begin
          out_valid <= 1'b1;
          out_data  <= hold_b;
          out_sop   <= hold_sop;
          out_eop   <= 1'b1;
          out_err   <= end_err;
        end
        hold_v <= 1'b0;
      end
    end
  end

  // packet tracker used only by the properties below
  logic in_pkt;
  always_ff @(posedge clk) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (out_valid) in_pkt <= !out_eop;
  end

  p_marks_need_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);
  p_sop_opens_packet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_pkt) |-> out_sop);
  p_no_sop_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_pkt) |-> !out_sop);
  p_err_on_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_eop && out_valid));
  p_gap_after_eop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> !out_valid);
endmodule

// File: rtl/mii_rx_deser.sv
module mii_rx_deser #(
  parameter int               NIB_W  = 4,
  parameter int               BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SFD   = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mii_rx_en,
  input  logic [NIB_W-1:0]  mii_rx_d,
  input  logic              mii_rx_er,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err
);
  logic             s_en;
  logic [NIB_W-1:0] s_d;
  logic             s_er;
  logic             frame_start;
  logic             frame_stop;

  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;
  logic              byte_first;
  logic              frame_end;
  logic              end_err;

  mii_rx_sampler #(.NIB_W(NIB_W)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .rx_en(mii_rx_en), .rx_d(mii_rx_d), .rx_er(mii_rx_er),
    .s_en(s_en), .s_d(s_d), .s_er(s_er),
    .frame_start(frame_start), .frame_stop(frame_stop)
  );

  mii_rx_framer #(.NIB_W(NIB_W), .BYTE_W(BYTE_W), .SFD(SFD)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .s_en(s_en), .s_d(s_d), .s_er(s_er),
    .frame_start(frame_start), .frame_stop(frame_stop),
    .byte_stb(byte_stb), .byte_val(byte_val), .byte_first(byte_first),
    .frame_end(frame_end), .end_err(end_err)
  );

  mii_rx_outstage #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .byte_stb(byte_stb), .byte_val(byte_val), .byte_first(byte_first),
    .frame_end(frame_end), .end_err(end_err),
    .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err)
  );

  // R1: nothing leaves the block unless a frame was in progress recently
  p_quiet_without_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(s_en) || $past(frame_stop)));
endmodule

// File: tb/mii_rx_deser_test.sv
`timescale 1ns/1ps
module mii_rx_deser_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mii_rx_en = 1'b0;
  logic [3:0] mii_rx_d = 4'h0;
  logic       mii_rx_er = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sop, out_eop, out_err;

  always #2 clk = ~clk;

  mii_rx_deser uut (
    .clk(clk), .rst_n(rst_n),
    .mii_rx_en(mii_rx_en), .mii_rx_d(mii_rx_d), .mii_rx_er(mii_rx_er),
    .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] cd [0:63];
  bit         cs [0:63];
  bit         ce [0:63];
  bit         cr [0:63];
  int         cn = 0;
  logic [7:0] ed [0:63];
  bit         es [0:63];
  bit         ee [0:63];
  bit         er [0:63];
  int         en = 0;

  always @(posedge clk) begin
    #1;
    if (out_valid && cn < 64) begin
      cd[cn] = out_data; cs[cn] = out_sop; ce[cn] = out_eop; cr[cn] = out_err;
      cn = cn + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'(seed * 29 + i * 53 + 7);
  endfunction

  task automatic nib(input logic [3:0] d, input bit e);
    mii_rx_en = 1'b1; mii_rx_d = d; mii_rx_er = e;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      mii_rx_en = 1'b0; mii_rx_d = 4'($urandom); mii_rx_er = i[0];
      @(negedge clk);
    end
    mii_rx_er = 1'b0;
  endtask

  // drives one frame and appends the beats it should produce
  task automatic run_frame(input int nb, input int pre, input int errn,
                           input bit odd, input int gap, input int seed);
    int k = 0;
    for (int i = 0; i < nb; i++) begin
      ed[en] = pay(seed, i); es[en] = (i == 0); ee[en] = (i == nb - 1);
      er[en] = (i == nb - 1) && (errn >= 0 || odd);
      en++;
    end
    for (int i = 0; i < pre; i++) begin nib(4'h5, k == errn); k++; end
    nib(4'h5, k == errn); k++;
    nib(4'hD, k == errn); k++;
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b = pay(seed, i);
      nib(b[3:0], k == errn); k++;
      nib(b[7:4], k == errn); k++;
    end
    if (odd) begin nib(4'hA, k == errn); k++; end
    idle(gap);
  endtask

  task automatic verify(input string tag);
    repeat (6) @(negedge clk);
    check(cn == en, tag, "beat count", cn, en);
    for (int i = 0; i < en && i < cn; i++) begin
      check(cd[i] == ed[i], tag, $sformatf("data[%0d]", i), cd[i], ed[i]);
      check({cs[i], ce[i], cr[i]} == {es[i], ee[i], er[i]}, tag,
            $sformatf("sop/eop/err[%0d]", i), {cs[i], ce[i], cr[i]}, {es[i], ee[i], er[i]});
    end
    cn = 0; en = 0;
  endtask

  task automatic t_reset;
    check({out_valid, out_sop, out_eop, out_err} == 4'b0, "R1", "reset outputs",
          {out_valid, out_sop, out_eop, out_err}, 0);
  endtask

  task automatic t_noise;
    idle(12);
    verify("R10 noise while enable low");
  endtask

  task automatic t_basic;
    run_frame(4, 14, -1, 1'b0, 4, 1);
    verify("R2 R3 R4 basic frame");
  endtask

  task automatic t_odd_preamble;
    run_frame(3, 7, -1, 1'b0, 3, 2);
    verify("R2 odd preamble length");
  endtask

  task automatic t_err_preamble;
    run_frame(5, 10, 3, 1'b0, 3, 3);
    verify("R5 error in preamble");
    run_frame(5, 10, -1, 1'b0, 3, 4);
    verify("R6 clean frame after error");
  endtask

  task automatic t_err_last;
    run_frame(3, 8, 8 + 2 + 6 - 1, 1'b0, 3, 5);
    verify("R5 error on final nibble");
  endtask

  task automatic t_odd;
    run_frame(4, 8, -1, 1'b1, 3, 6);
    verify("R7 odd nibble count");
    run_frame(2, 8, 8 + 2 + 4, 1'b1, 3, 7);
    verify("R7 R5 odd tail with error");
  endtask

  task automatic t_no_sfd;
    for (int i = 0; i < 20; i++) nib(4'h5, i == 4);
    idle(3);
    verify("R2 frame without delimiter");
  endtask

  task automatic t_short;
    run_frame(0, 8, -1, 1'b1, 3, 8);
    verify("R8 half byte after delimiter");
    run_frame(0, 8, -1, 1'b0, 3, 8);
    verify("R8 delimiter only");
  endtask

  task automatic t_one_byte;
    run_frame(1, 8, -1, 1'b0, 3, 9);
    verify("R4 one-byte frame");
  endtask

  task automatic t_back_to_back;
    run_frame(3, 6, 6 + 2 + 2, 1'b0, 1, 10);
    run_frame(2, 6, -1, 1'b0, 1, 11);
    run_frame(4, 5, -1, 1'b1, 3, 12);
    verify("R9 back-to-back frames");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noise();
    t_basic();
    t_odd_preamble();
    t_err_preamble();
    t_err_last();
    t_odd();
    t_no_sfd();
    t_short();
    t_one_byte();
    t_back_to_back();
    t_noise();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule